// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-line general-purpose I/O port. Software reaches its data register through a window of word addresses. The address of each access doubles as a per-pin bit mask, so one store can change a single pin, or any chosen subset of pins, without first reading the register back. A second register sets the direction of each pin. An output-enable bit goes to the pad for every pin that is set as an output.

The bus is a plain synchronous register interface: a byte address, a write strobe, write data and a read-data output. Reads are combinational from the current address. Writes take effect at the rising clock edge. Pin inputs pass through a two-stage synchroniser before they can appear on the read path. A pin set as an output reads back the value it is driving.

Top module: `gpio_masked_port`

## Requirements
- R1: After synchronous reset, the direction register, the output data register, `pin_oe` and `pin_out` are all 0 on the eight lines.
- R2: Byte addresses 0x000 to 0x3FF select the data window. Address bit n+2 is the mask bit for pin n. Address bits [1:0] have no effect.
- R3: A write to the data window loads `bus_wdata[n]` into output bit n only where mask bit n is 1. Every other output bit keeps its previous value.
- R4: A read from the data window returns 0 in every bit whose mask bit is 0.
- R5: In a data read, a masked-in pin whose direction bit is 1 returns the value on `pin_out` for that pin.
- R6: In a data read, a masked-in pin whose direction bit is 0 returns its input level after a two-flop synchroniser. A pin change set up before clock edge k becomes visible on `bus_rdata` after edge k+1.
- R7: Byte address 0x400 (bits [1:0] ignored) is the direction register. Bit value 1 makes a pin an output and 0 makes it an input. `pin_oe` equals the register, and a read at that address returns it.
- R8: The output data register can be written whatever the direction. A value written while a pin is an input appears on `pin_out` at once, and it is driven as soon as the pin's direction bit is set.
- R9: Reads from any other address return 0. Writes to any other address change neither the direction register nor the output data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output data register |
| pin_oe | output | 8 | Per-pin output enable (direction) |

## Verification
The assertions assume that `bus_addr`, `bus_we` and `bus_wdata` are stable around each rising edge and change only between edges. They also assume that `pin_in` is the one input that may change at any time. The stimulus keeps to this by changing every input, pins included, half a period away from the sampling edge. Because of this, the synchroniser latency stated in R6 is exactly two edges and can be predicted. The address stimulus covers all three decode regions, including their boundary words and nonzero low address bits. This keeps the decode-dependent properties active under both directions of every pin.

// File: rtl/gmp_pkg.sv
package gmp_pkg;
    localparam int unsigned LINES   = 8;
    localparam int unsigned ADDR_W  = LINES + 4;
    localparam int unsigned WORD_W  = ADDR_W - 2;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1) << LINES;

    typedef logic [LINES-1:0] lines_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } sel_e;

    typedef struct packed {
        sel_e   sel;
        lines_t mask;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.mask = a[LINES+1:2];
        if (a[ADDR_W-1:LINES+2] == '0)
            d.sel = SEL_DATA;
        else if (a[ADDR_W-1:2] == DIR_WORD)
            d.sel = SEL_DIR;
        else
            d.sel = SEL_NONE;
        return d;
    endfunction

    function automatic lines_t merge(input lines_t old_v, input lines_t new_v,
                                     input lines_t mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction
endpackage

// File: rtl/gmp_sync.sv
module gmp_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/gmp_regs.sv
module gmp_regs
    import gmp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  dec_t   dec,
    input  lines_t wdata,
    output lines_t out_q,
    output lines_t dir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (we) begin
            unique case (dec.sel)
                SEL_DATA: out_q <= merge(out_q, wdata, dec.mask);
                SEL_DIR:  dir_q <= wdata;
                default:  ;
            endcase
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (out_q == '0 && dir_q == '0));

    a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
        (we && dec.sel == SEL_DATA) |=> (((out_q ^ $past(out_q)) & ~$past(dec.mask)) == '0));

    a_r9_dir_only_at_offset: assert property (@(posedge clk) disable iff (rst)
        !(we && dec.sel == SEL_DIR) |=> $stable(dir_q));

    a_r9_out_only_in_window: assert property (@(posedge clk) disable iff (rst)
        !(we && dec.sel == SEL_DATA) |=> $stable(out_q));
endmodule

// File: rtl/gmp_rdmux.sv
module gmp_rdmux
    import gmp_pkg::*;
(
    input  dec_t   dec,
    input  lines_t out_q,
    input  lines_t dir_q,
    input  lines_t pin_sync,
    output lines_t rdata
);
    lines_t level;

    always_comb begin
        for (int n = 0; n < LINES; n++)
            level[n] = dir_q[n] ? out_q[n] : pin_sync[n];
        unique case (dec.sel)
            SEL_DATA: rdata = level & dec.mask;
            SEL_DIR:  rdata = dir_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gmp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe
);
    dec_t   dec;
    lines_t out_q, dir_q, pin_sync;

    assign dec = decode(bus_addr);

    gmp_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pin_in),
        .d_out (pin_sync)
    );

    gmp_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .dec   (dec),
        .wdata (bus_wdata),
        .out_q (out_q),
        .dir_q (dir_q)
    );

    gmp_rdmux u_rd (
        .dec      (dec),
        .out_q    (out_q),
        .dir_q    (dir_q),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    a_r4_masked_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[ADDR_W-1:LINES+2] == '0) |-> ((bus_rdata & ~bus_addr[LINES+1:2]) == '0));

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[ADDR_W-1:LINES+2] != '0 && bus_addr[ADDR_W-1:2] != DIR_WORD)
        |-> (bus_rdata == '0));

    a_r5_output_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[ADDR_W-1:LINES+2] == '0)
        |-> ((bus_rdata & pin_oe) == (pin_out & pin_oe & bus_addr[LINES+1:2])));
endmodule

// File: tb/sim_gpio_masked_port.sv
module sim_gpio_masked_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [7:0] m_out = '0, m_dir = '0, m_s1 = '0, m_s2 = '0;

    always #2.5 clk = ~clk;

    gpio_masked_port u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h (addr %03h)", tag, act, exp, bus_addr);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [11:0] a);
        logic [7:0] lvl;
        if (a < 12'h400) begin
            lvl = 8'h00;
            for (int n = 0; n < 8; n++)
                lvl[n] = m_dir[n] ? m_out[n] : m_s2[n];
            return lvl & a[9:2];
        end
        if (a[11:2] == 10'h100) return m_dir;
        return 8'h00;
    endfunction

    function automatic string region_tag(input logic [11:0] a);
        if (a < 12'h400) return "R4";
        if (a[11:2] == 10'h100) return "R7";
        return "R9";
    endfunction

    // One cycle: drive at negedge, compare combinational outputs, then advance model at posedge
    task automatic step(input logic [11:0] a, input logic we, input logic [7:0] wd,
                        input logic [7:0] pins, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd; pin_in = pins;
        #1;
        check(tag == "" ? region_tag(a) : tag, bus_rdata, model_read(a));
        check("R3", pin_out, m_out);
        check("R7", pin_oe, m_dir);
        @(posedge clk);
        m_s2 = m_s1;
        m_s1 = pins;
        if (we) begin
            if (a < 12'h400) m_out = (m_out & ~a[9:2]) | (wd & a[9:2]);
            else if (a[11:2] == 10'h100) m_dir = wd;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr;
        logic [7:0]  pins;
        logic [11:0] a;
        pins = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", pin_out, 8'h00);
        check("R1", pin_oe, 8'h00);
        bus_addr = 12'h400; #1;
        check("R1", bus_rdata, 8'h00);

        // R8: write data while all inputs, then switch direction
        step(12'h3FC, 1, 8'hA5, pins, "R8");
        step(12'h3FC, 0, 8'h00, pins, "R8");
        check("R8", pin_out, 8'hA5);
        step(12'h400, 1, 8'h0F, pins, "R7");
        step(12'h403, 0, 8'h00, pins, "R7");
        check("R8", pin_oe, 8'h0F);

        // R3: masked write of two pins
        step(12'h00C, 1, 8'h00, pins, "R3");
        step(12'h3FC, 0, 8'h00, pins, "R5");
        check("R3", pin_out, 8'hA4);

        // R3: per-pin single-bit writes
        for (int n = 0; n < 8; n++)
            step(12'(1 << (n + 2)), 1, 8'hFF, pins, "R3");
        check("R3", pin_out, 8'hFF);

        // R6: input pins through synchroniser
        pins = 8'h5A;
        step(12'h3FC, 0, 8'h00, pins, "R6");
        step(12'h3FC, 0, 8'h00, pins, "R6");
        step(12'h3FC, 0, 8'h00, pins, "R6");
        check("R6", bus_rdata, 8'h5F);

        // R2: low address bits ignored, masks from address
        step(12'h3FF, 1, 8'h00, pins, "R2");
        step(12'h0F1, 0, 8'h00, pins, "R2");
        step(12'h202, 0, 8'h00, pins, "R2");

        // R9: unmapped accesses
        step(12'h404, 1, 8'hFF, pins, "R9");
        step(12'h800, 1, 8'hFF, pins, "R9");
        step(12'hFFC, 1, 8'hFF, pins, "R9");
        step(12'h7FC, 1, 8'h33, pins, "R9");
        check("R9", pin_oe, 8'h0F);
        check("R9", pin_out, 8'h00);

        // mixed traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            unique case (lfsr[2:0])
                3'd0:    a = 12'h400 | 12'(lfsr[4:3]);
                3'd1:    a = {2'b01, lfsr[15:6]} | 12'h400;
                3'd2:    a = 12'h3FC;
                default: a = {2'b00, lfsr[15:6]};
            endcase
            if (lfsr[5]) pins = lfsr[13:6];
            step(a, lfsr[1] ^ lfsr[9], lfsr[15:8], pins, "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule